// File: doc/BRIEF.md
# Serial Register-File Target with Protocol Alarms

This block is a serial-peripheral target that gives a host access to a small bank of 16-bit configuration registers. Every access is one frame of exactly 24 serial clocks, sent most significant bit first, with chip select held low for the whole frame. The first bit says whether the frame reads or writes. The next six bits select the register, sixteen data bits follow, and the frame ends with a parity slot. The register contents are driven in parallel on a wide output bus, so that neighbouring analog control logic can use them directly.

The serial pins are brought into the system clock domain through two-stage synchronizers and sampled on edges detected there. A frame controller with four states watches chip select: `ST_IDLE` waits for chip select to go low; `ST_SHIFT` collects bits while chip select stays low; `ST_COMMIT` lasts one cycle after chip select rises and judges the frame; `ST_SOFTRST` lasts one cycle and loads the defaults. The transitions are `ST_IDLE`→`ST_SHIFT` when chip select is low, `ST_SHIFT`→`ST_COMMIT` when chip select rises, `ST_COMMIT`→`ST_SOFTRST` on a valid write that sets the soft-reset bit, `ST_COMMIT`→`ST_IDLE` otherwise, and `ST_SOFTRST`→`ST_IDLE` always. Frames with the wrong length, a parity error or an address outside the implemented set raise sticky alarm flags.

Top module: `rm_spi_target`

## Requirements
- R1: A frame is 24 bits sent MSB first. Frame bit 23 is 1 for a read and 0 for a write, bits 22:17 hold the address, bits 16:1 hold the data and bit 0 is the parity slot. A valid write to an implemented address stores the data, and a later read returns it. This holds for the mask register at 0x02 and for the full-width registers 0x03 and 0x05 to 0x0A.
- R2: In SPI mode 0, during a read frame the target drives register bits 15 down to 0 on `spi_miso` while the host clocks frame bits 16 down to 1. `spi_miso` changes after falling serial-clock edges and is low while chip select is high.
- R3: Register 0x00 holds a writable parity-enable bit at bit 15 and the soft-reset bit at bit 14. Bits 11:4 always read 0x0A, bits 3:0 read the `REVISION` parameter (default 1), and bits 13:12 read 0. Writes to read-only bits have no effect, so after reset the register reads 0x00A1.
- R4: Register 0x01 holds the alarm flags: bit 15 parity, bit 14 too few clocks, bit 13 too many clocks, bit 12 address range. The other bits read 0. A flag stays set until a write puts 1 in its position. Writing 0 leaves it set.
- R5: A frame with fewer than 24 rising serial-clock edges, including a frame with none, sets alarm bit 14 and changes no register.
- R6: A frame with more than 24 rising serial-clock edges sets alarm bit 13 and changes no register.
- R7: An address outside {0x00–0x03, 0x05–0x0A} sets alarm bit 12. A read of such an address returns 0, and a write to it changes no register.
- R8: When parity is enabled, a 24-bit frame whose count of 1 bits is even sets alarm bit 15 and its write is blocked. When parity is disabled, bit 0 is ignored.
- R9: A valid write of 1 to bit 14 of 0x00 returns every register to its default (0x0A reads 0xE700; every other writable register, including parity enable, reads 0) and clears all alarms. Bit 14 then reads 0.
- R10: `reg_bus` carries the register at address a in bits 16a+15:16a, and the slot for address 0x04 is zero. After reset it carries the default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing one access |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| reg_bus | output | 176 | Parallel image of all register slots, 16 bits each |

## Verification
The in-RTL properties check on every cycle that the frame controller visits the commit state for exactly one cycle and enters the reset state only from it, that register contents hold when no write, alarm or soft reset is pending, that alarm flags do not clear without a write to the alarm address, that a soft reset leaves the defaults behind, and that the read line stays quiet between frames. Only the bench scenarios can show the serial timing of read data, the judgement of short, long, badly addressed and bad-parity frames, the exact alarm codes they produce, and the way the parity-enable setting changes whether a frame is accepted.

// File: rtl/rm_pkg.sv
`timescale 1ns/1ps
package rm_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 6;
    localparam int FRAME_W  = 2 + ADDR_W + DATA_W;
    localparam int HDR_W    = 1 + ADDR_W;
    localparam int NUM_ADDR = 11;
    localparam int IDX_W    = $clog2(NUM_ADDR);
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int SEL_W    = $clog2(DATA_W);
    localparam logic [7:0] CHIP_ID = 8'h0A;
    localparam int GAP_ADDR   = 4;
    localparam int CTRL_ADDR  = 0;
    localparam int ALARM_ADDR = 1;

    // alarm flag order inside the 4-bit alarm vector: {parity, short, long, range}
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_COMMIT, ST_SOFTRST} fsm_t;

    function automatic logic addr_valid(input logic [ADDR_W-1:0] a);
        return (a < ADDR_W'(NUM_ADDR)) && (a != ADDR_W'(GAP_ADDR));
    endfunction

    function automatic logic [DATA_W-1:0] slot_default(input int idx);
        return (idx == NUM_ADDR - 1) ? 16'hE700 : 16'h0000;
    endfunction
endpackage

// File: rtl/rm_sync.sv
`timescale 1ns/1ps
module rm_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rm_shifter.sv
`timescale 1ns/1ps
module rm_shifter
    import rm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                cs_n_s,
    input  logic                mosi_s,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    bit_cnt,
    output logic [HDR_W-1:0]    hdr,
    output logic                cs_rise,
    output logic                miso
);
    logic sclk_d, cs_d, rise, fall;
    logic [SEL_W-1:0] sel;

    assign rise    = sclk_s & ~sclk_d & ~cs_n_s;
    assign fall    = ~sclk_s & sclk_d & ~cs_n_s;
    assign cs_rise = cs_n_s & ~cs_d;
    assign sel     = SEL_W'(CNT_W'(FRAME_W - 2) - bit_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
            frame   <= '0;
            bit_cnt <= '0;
            hdr     <= '0;
            miso    <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
            if (!cs_n_s && cs_d) begin
                bit_cnt <= '0;
                hdr     <= '0;
            end else if (rise) begin
                frame <= {frame[FRAME_W-2:0], mosi_s};
                if (bit_cnt == CNT_W'(HDR_W - 1))
                    hdr <= {frame[HDR_W-2:0], mosi_s};
                if (bit_cnt != CNT_W'(FRAME_W + 1))
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (cs_n_s)
                miso <= 1'b0;
            else if (fall)
                miso <= hdr[HDR_W-1] && bit_cnt >= CNT_W'(HDR_W)
                        && bit_cnt <= CNT_W'(FRAME_W - 2) && rd_data[sel];
        end
    end

    // R2
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !miso);
endmodule

// File: rtl/rm_regfile.sv
`timescale 1ns/1ps
module rm_regfile
    import rm_pkg::*;
#(
    parameter logic [3:0] REVISION = 4'h1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [3:0]                 alarm_set,
    input  logic                       soft_rst,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       parity_en,
    output logic [NUM_ADDR-1:0][DATA_W-1:0] img
);
    logic [3:0] alarm_q;

    for (genvar a = 0; a < NUM_ADDR; a++) begin : g_slot
        if (a == CTRL_ADDR) begin : g_ctrl
            logic par_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       par_q <= 1'b0;
                else if (soft_rst) par_q <= 1'b0;
                else if (wr_en && wr_addr == ADDR_W'(a)) par_q <= wr_data[15];
            end
            assign img[a] = {par_q, 3'b000, CHIP_ID, REVISION};
        end else if (a == ALARM_ADDR) begin : g_alarm
            logic [3:0] clr;
            assign clr = (wr_en && wr_addr == ADDR_W'(a)) ? wr_data[15:12] : 4'h0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        alarm_q <= 4'h0;
                else if (soft_rst) alarm_q <= 4'h0;
                else               alarm_q <= (alarm_q & ~clr) | alarm_set;
            end
            assign img[a] = {alarm_q, 12'h000};
        end else if (a == GAP_ADDR) begin : g_gap
            assign img[a] = '0;
        end else begin : g_cfg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= slot_default(a);
                else if (soft_rst) q <= slot_default(a);
                else if (wr_en && wr_addr == ADDR_W'(a)) q <= wr_data;
            end
            assign img[a] = q;
        end
    end

    assign parity_en = img[CTRL_ADDR][15];
    assign rd_data   = addr_valid(rd_addr) ? img[rd_addr[IDX_W-1:0]] : '0;

    // R4
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == ADDR_W'(ALARM_ADDR)) && !soft_rst)
        |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !soft_rst && alarm_set == 4'h0) |=> $stable(img));
    // R9
    soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (img[NUM_ADDR-1] == 16'hE700 && alarm_q == 4'h0 && !parity_en));
endmodule

// File: rtl/rm_spi_target.sv
`timescale 1ns/1ps
module rm_spi_target
    import rm_pkg::*;
#(
    parameter logic [3:0] REVISION = 4'h1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_sclk,
    input  logic                         spi_cs_n,
    input  logic                         spi_mosi,
    output logic                         spi_miso,
    output logic [NUM_ADDR*DATA_W-1:0]   reg_bus
);
    logic sclk_s, cs_n_s, mosi_s, cs_rise, parity_en;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bit_cnt;
    logic [HDR_W-1:0]   hdr;
    logic [DATA_W-1:0]  rd_data;
    logic [NUM_ADDR-1:0][DATA_W-1:0] img;
    fsm_t state, nxt;

    logic len_ok, len_short, len_long, addr_bad, par_bad, soft_go;
    logic wr_en, soft_rst;
    logic [3:0] alarm_set;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;

    rm_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk, spi_cs_n, spi_mosi}),
        .q({sclk_s, cs_n_s, mosi_s})
    );

    rm_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
        .mosi_s(mosi_s), .rd_data(rd_data), .frame(frame),
        .bit_cnt(bit_cnt), .hdr(hdr), .cs_rise(cs_rise), .miso(spi_miso)
    );

    rm_regfile #(.REVISION(REVISION)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(f_addr),
        .wr_data(f_data), .alarm_set(alarm_set), .soft_rst(soft_rst),
        .rd_addr(hdr[ADDR_W-1:0]), .rd_data(rd_data),
        .parity_en(parity_en), .img(img)
    );

    assign reg_bus = img;

    // frame judgement
    assign f_addr    = frame[FRAME_W-2 -: ADDR_W];
    assign f_data    = frame[DATA_W:1];
    assign len_ok    = (bit_cnt == CNT_W'(FRAME_W));
    assign len_short = (bit_cnt <  CNT_W'(FRAME_W));
    assign len_long  = (bit_cnt >  CNT_W'(FRAME_W));
    assign addr_bad  = !addr_valid(f_addr);
    assign par_bad   = parity_en && !(^frame);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (!cs_n_s) nxt = ST_SHIFT;
            ST_SHIFT:   if (cs_rise) nxt = ST_COMMIT;
            ST_COMMIT:  nxt = soft_go ? ST_SOFTRST : ST_IDLE;
            ST_SOFTRST: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en     = 1'b0;
        soft_go   = 1'b0;
        soft_rst  = 1'b0;
        alarm_set = 4'h0;
        unique case (state)
            ST_COMMIT: begin
                alarm_set = {len_ok & par_bad, len_short, len_long, len_ok & addr_bad};
                wr_en     = len_ok && !frame[FRAME_W-1] && !addr_bad && !par_bad;
                soft_go   = wr_en && f_addr == ADDR_W'(CTRL_ADDR) && f_data[14];
            end
            ST_SOFTRST: soft_rst = 1'b1;
            default: ;
        endcase
    end

    // R1
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state != ST_COMMIT));
    // R9
    softrst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFTRST) |-> ($past(state) == ST_COMMIT));
    // R9
    softrst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFTRST) |=> (state == ST_IDLE));
endmodule

// File: tb/rm_spi_target_test.sv
`timescale 1ns/1ps
module rm_spi_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8 * CLK_PERIOD;
    localparam int NSLOT = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [NSLOT*16-1:0] reg_bus;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    rm_spi_target uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .reg_bus(reg_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {address, write data, expected readback}
    localparam logic [37:0] VEC [9] = '{
        {6'h03, 16'hA5A5, 16'hA5A5},
        {6'h05, 16'h1234, 16'h1234},
        {6'h06, 16'hFFFF, 16'hFFFF},
        {6'h07, 16'h0001, 16'h0001},
        {6'h08, 16'h8000, 16'h8000},
        {6'h09, 16'h5A5A, 16'h5A5A},
        {6'h0A, 16'h0F0F, 16'h0F0F},
        {6'h02, 16'hF00F, 16'hF00F},
        {6'h00, 16'h8FFF, 16'h80A1}
    };

    function automatic logic [15:0] slot(input int a);
        return reg_bus[16*a +: 16];
    endfunction

    function automatic logic [15:0] dflt(input int a);
        if (a == 0) return 16'h00A1;
        if (a == 10) return 16'hE700;
        return 16'h0000;
    endfunction

    function automatic logic [23:0] mk(input logic r, input logic [5:0] a, input logic [15:0] d);
        return {r, a, d, ~^{r, a, d}};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input int nbits, input logic [23:0] f, output logic [15:0] rd);
        rd = '0;
        cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? f[23-i] : 1'b0;
            #(HALF);
            sclk = 1'b1;
            if (i >= 7 && i <= 22) rd[22-i] = miso;
            #(HALF);
            sclk = 1'b0;
        end
        #(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        #(3 * HALF);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        logic [15:0] dummy;
        xfer(24, mk(1'b0, a, d), dummy);
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [15:0] v);
        xfer(24, mk(1'b1, a, 16'h0000), v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] saved [NSLOT];
        #2;
        #(CLK_PERIOD * 5);
        rst_n = 1'b1;
        #(CLK_PERIOD * 5);

        // reset state
        check("R3 ctrl reset", slot(0), 16'h00A1);
        check("R10 slot10 reset", slot(10), 16'hE700);
        check("R4 alarm reset", slot(1), 16'h0000);
        check("R10 slot3 reset", slot(3), 16'h0000);
        check("R2 miso idle", {15'h0, miso}, 16'h0000);
        rd_reg(6'h00, v);
        check("R3 ctrl read", v, 16'h00A1);
        rd_reg(6'h0A, v);
        check("R2 read slot10", v, 16'hE700);

        // table walk
        for (int k = 0; k < 9; k++) begin
            wr(VEC[k][37:32], VEC[k][31:16]);
            check("R10 bus after write", slot(int'(VEC[k][37:32])), VEC[k][15:0]);
            rd_reg(VEC[k][37:32], v);
            check("R1 readback", v, VEC[k][15:0]);
        end

        // R8 parity enabled now: bad parity write blocked
        xfer(24, mk(1'b0, 6'h03, 16'h1111) ^ 24'h1, v);
        check("R8 write blocked", slot(3), 16'hA5A5);
        rd_reg(6'h01, v);
        check("R8 parity alarm", v, 16'h8000);
        wr(6'h01, 16'h8000);
        check("R4 clear parity", slot(1), 16'h0000);

        // R5 short frame
        xfer(10, mk(1'b0, 6'h03, 16'h2222), v);
        check("R5 short no write", slot(3), 16'hA5A5);
        rd_reg(6'h01, v);
        check("R5 short alarm", v, 16'h4000);
        wr(6'h01, 16'h0000);
        check("R4 zero keeps", slot(1), 16'h4000);
        wr(6'h01, 16'h4000);
        check("R4 one clears", slot(1), 16'h0000);
        xfer(0, 24'h0, v);
        check("R5 empty frame", slot(1), 16'h4000);
        wr(6'h01, 16'hF000);

        // R6 long frame
        xfer(30, mk(1'b0, 6'h03, 16'h3333), v);
        check("R6 long no write", slot(3), 16'hA5A5);
        check("R6 long alarm", slot(1), 16'h2000);
        wr(6'h01, 16'h2000);

        // R7 unimplemented address
        for (int a = 0; a < NSLOT; a++) saved[a] = slot(a);
        wr(6'h04, 16'hFFFF);
        for (int a = 0; a < NSLOT; a++)
            if (a != 1) check("R7 gap write ignored", slot(a), saved[a]);
        check("R7 range alarm", slot(1), 16'h1000);
        rd_reg(6'h0C, v);
        check("R7 read outside zero", v, 16'h0000);
        rd_reg(6'h3F, v);
        check("R7 read top zero", v, 16'h0000);
        wr(6'h01, 16'h1000);
        check("R7 alarm cleared", slot(1), 16'h0000);

        // R8 parity disabled: bit 0 ignored
        wr(6'h00, 16'h0000);
        check("R3 parity off", slot(0), 16'h00A1);
        xfer(24, mk(1'b0, 6'h03, 16'h7777) ^ 24'h1, v);
        check("R8 ignored parity", slot(3), 16'h7777);
        check("R8 no alarm", slot(1), 16'h0000);

        // R9 soft reset
        xfer(5, 24'h0, v);
        wr(6'h00, 16'hC000);
        for (int a = 0; a < NSLOT; a++) check("R9 default", slot(a), dflt(a));
        rd_reg(6'h00, v);
        check("R9 bit14 self clear", v, 16'h00A1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule